// File: doc/BRIEF.md
# GF(2^4) Key-Matched Message Recovery Engine

This block recovers a 4-bit plaintext from a 4-bit ciphertext produced by field multiplication. The multiplier key is the secret. The reduction polynomial is shared by both ends. The block does not multiply by an inverse of the key. Instead, it first fills an on-chip product table with key × m for every candidate m, using the same shift-and-reduce multiplication as the encoder. It then scans that table from candidate 0 upward and stops at the first entry that equals the ciphertext.

A request starts with a one-cycle `start` pulse while the engine is idle. The ciphertext, key and polynomial are captured on that edge. `busy` stays high while the table is built and searched. The engine ends with one of two registered results:

- `found` high, with the matching candidate on `msg_out`.
- `miss` high, when no entry matched.

A zero key maps every candidate to zero. In that case a zero ciphertext is reported as candidate 0 with `ambig` raised, and any other ciphertext is reported as a miss. A wrong nonzero key still lands on some entry, so it yields a message that differs from the original.

Top module: `gf_lookup_decoder`

## Requirements
- R1: During and right after synchronous reset, `busy`, `found`, `miss` and `ambig` are 0 and `msg_out` is 0.
- R2: A `start` pulse sampled while `busy` is low captures `cipher_in`, `key_in` and `poly_in`. `busy` is 1 from the next cycle on.
- R3: A `start` pulse while `busy` is high is ignored. The result belongs to the operands captured by the accepted pulse.
- R4: Products are computed in GF(2^W) modulo x^W + poly, where bit i of `poly_in` is the coefficient of x^i (x^4+x+1 is `4'b0011`). Whenever `found` is 1, key × `msg_out` equals the captured ciphertext.
- R5: With an irreducible polynomial and a nonzero key, decoding the product key × m returns m with `found` = 1, for every m and every nonzero key.
- R6: Decoding with a nonzero key different from the one used to encrypt a nonzero m returns a message other than m.
- R7: `busy` stays high for exactly 2^W + 2 + m cycles when candidate m matches. It stays high for exactly 2^(W+1) + 1 cycles when nothing matches. It falls in the same cycle that `found` or `miss` rises.
- R8: With key 0 and a nonzero ciphertext, the result is `miss` = 1 and `found` = 0.
- R9: With key 0 and ciphertext 0, the result is `found` = 1, `msg_out` = 0 and `ambig` = 1. `ambig` is 0 for every nonzero key.
- R10: `found` and `miss` are never both 1. All result outputs hold their values until the next accepted `start`, which clears `found`, `miss` and `ambig`.
- R11: When several candidates give the same product (reducible polynomial), the lowest such candidate is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| cipher_in | input | W | Ciphertext to decode |
| key_in | input | W | Multiplier key |
| poly_in | input | W | Low coefficients of the reduction polynomial (x^W implied) |
| msg_out | output | W | Recovered candidate |
| found | output | 1 | A matching candidate was found |
| miss | output | 1 | No candidate matched |
| ambig | output | 1 | Match obtained with a zero key |
| busy | output | 1 | Table build or search in progress |

## Verification
The assertions watch, on every cycle, the rules that hold locally in time:
- the captured operands stay frozen while busy;
- `found` and `miss` are exclusive;
- a falling `busy` always comes with a result;
- a reported match is consistent with the field product;
- `ambig` only appears with a zero key and a zero result.

Only the bench scenarios can show the rest:
- that every one of the 240 key/message pairs decodes back to its message;
- that wrong keys give other messages;
- the exact cycle counts;
- that the lowest duplicate wins;
- that a start pulse during a run leaves the result untouched.

// File: rtl/gf_dec_pkg.sv
package gf_dec_pkg;

  localparam int GF_W_DEF = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUILD = 2'd1,
    ST_SCAN  = 2'd2
  } dec_state_t;

  // Width-generic reference product for checks (up to 16-bit fields).
  function automatic logic [15:0] gf_mul_ref(input logic [15:0] a,
                                             input logic [15:0] b,
                                             input logic [15:0] poly,
                                             input int          w);
    logic [15:0] r;
    logic [15:0] msk;
    r   = '0;
    msk = 16'((32'd1 << w) - 1);
    for (int i = 15; i >= 0; i--) begin
      if (i < w) begin
        if (r[w-1]) r = ((r << 1) ^ poly) & msk;
        else        r = (r << 1) & msk;
        if (b[i]) r = r ^ (a & msk);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/gf_mul_unit.sv
module gf_mul_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] poly,
  output logic [W-1:0] p
);

  // MSB-first shift-and-add: each stage doubles, reduces, then adds a if b bit set.
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [W-1:0] prev;
    logic [W-1:0] shifted;
    logic [W-1:0] nxt;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_chain
      assign prev = g_stage[i-1].nxt;
    end
    assign shifted = {prev[W-2:0], 1'b0} ^ (prev[W-1] ? poly : '0);
    assign nxt     = shifted ^ (b[W-1-i] ? a : '0);
  end

  assign p = g_stage[W-1].nxt;

  // R4: a zero operand always yields a zero product
  always_comb begin
    p_zero_operand_r4: assert (!((a == '0) || (b == '0)) || (p == '0));
  end

endmodule

// File: rtl/gf_prod_table.sv
module gf_prod_table #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raddr,
  output logic [W-1:0] rdata
);

  localparam int DEPTH = 1 << W;

  logic [W-1:0] mem [0:DEPTH-1];

  // Synchronous write, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/gf_lookup_decoder.sv
module gf_lookup_decoder
  import gf_dec_pkg::*;
#(
  parameter int W = GF_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] cipher_in,
  input  logic [W-1:0] key_in,
  input  logic [W-1:0] poly_in,
  output logic [W-1:0] msg_out,
  output logic         found,
  output logic         miss,
  output logic         ambig,
  output logic         busy
);

  localparam logic [W-1:0] LAST = W'((1 << W) - 1);

  dec_state_t   state;
  logic [W-1:0] cipher_q, key_q, poly_q;
  logic [W-1:0] idx;
  logic [W-1:0] pidx;
  logic         pend;
  logic [W-1:0] prod;
  logic [W-1:0] rd_data;

  gf_mul_unit #(.W(W)) u_mul (
    .a    (key_q),
    .b    (idx),
    .poly (poly_q),
    .p    (prod)
  );

  gf_prod_table #(.W(W)) u_tbl (
    .clk   (clk),
    .we    (state == ST_BUILD),
    .waddr (idx),
    .wdata (prod),
    .raddr (idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cipher_q <= '0;
      key_q    <= '0;
      poly_q   <= '0;
      idx      <= '0;
      pidx     <= '0;
      pend     <= 1'b0;
      msg_out  <= '0;
      found    <= 1'b0;
      miss     <= 1'b0;
      ambig    <= 1'b0;
      busy     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cipher_q <= cipher_in;
            key_q    <= key_in;
            poly_q   <= poly_in;
            idx      <= '0;
            pend     <= 1'b0;
            found    <= 1'b0;
            miss     <= 1'b0;
            ambig    <= 1'b0;
            busy     <= 1'b1;
            state    <= ST_BUILD;
          end
        end
        ST_BUILD: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= ST_SCAN;
        end
        ST_SCAN: begin
          idx  <= idx + 1'b1;
          pidx <= idx;
          pend <= 1'b1;
          if (pend) begin
            if (rd_data == cipher_q) begin
              msg_out <= pidx;
              found   <= 1'b1;
              ambig   <= (key_q == '0);
              busy    <= 1'b0;
              state   <= ST_IDLE;
            end else if (pidx == LAST) begin
              miss  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: first cycle out of reset is idle with clear flags
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !found && !miss && !ambig));

  // R2: an idle start makes the engine busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R3: captured operands are frozen while a run is in progress
  p_hold_ops_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cipher_q) && $stable(key_q) && $stable(poly_q)));

  // R4: a reported match is a genuine field product
  p_match_consistent_r4: assert property (@(posedge clk) disable iff (rst)
    found |-> (W'(gf_mul_ref(16'(key_q), 16'(msg_out), 16'(poly_q), W)) == cipher_q));

  // R7: busy only drops together with a result
  p_busy_ends_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (found || miss));

  // R9: ambiguity only with zero key and zero result
  p_ambig_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ambig |-> (found && msg_out == '0 && key_q == '0));

  // R10: found and miss are exclusive
  p_excl_status_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({found, miss}));

endmodule

// File: tb/tb_gf_lookup_decoder.sv
`timescale 1ns/1ps
module tb_gf_lookup_decoder;

  localparam int W = 4;
  localparam logic [W-1:0] POLY_IRR = 4'b0011;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] cipher_in = '0, key_in = '0, poly_in = '0;
  logic [W-1:0] msg_out;
  logic         found, miss, ambig, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gf_lookup_decoder #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .cipher_in(cipher_in), .key_in(key_in), .poly_in(poly_in),
    .msg_out(msg_out), .found(found), .miss(miss), .ambig(ambig), .busy(busy)
  );

  // LSB-first schoolbook product, reduced per shift
  function automatic logic [W-1:0] tb_mul(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p);
    logic [W-1:0] r, aa;
    r = '0; aa = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) r ^= aa;
      if (aa[W-1]) aa = (aa << 1) ^ p;
      else         aa = aa << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Issue one request; n = busy-high cycle count. disturb pulses start mid-run.
  task automatic run(input logic [W-1:0] c, input logic [W-1:0] k, input logic [W-1:0] p,
                     input bit disturb, output int n);
    @(negedge clk);
    cipher_in = c; key_in = k; poly_in = p; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (disturb && n == 5) begin
        start = 1'b1; cipher_in = ~c; key_in = k ^ 4'd1; poly_in = ~p;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    logic [W-1:0] c, hm;
    logic hf, hmiss;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(!busy && !found && !miss && !ambig, "R1 flags after reset", {busy, found, miss, ambig}, 0);
    chk(msg_out == 0, "R1 msg after reset", msg_out, 0);

    // R2 / R7: start accepted, busy next cycle, exact latency on a match
    c = tb_mul(4'd3, 4'd7, POLY_IRR);
    run(c, 4'd3, POLY_IRR, 1'b0, n);
    chk(n == (1 << W) + 2 + 7, "R7 busy cycles on match", n, (1 << W) + 2 + 7);
    chk(found && msg_out == 7, "R2 captured request decoded", msg_out, 7);

    // R10: outputs held while idle with changing inputs
    @(negedge clk);
    cipher_in = 4'hF; key_in = 4'h0; poly_in = 4'h0;
    repeat (6) @(negedge clk);
    chk(found && !miss && msg_out == 7, "R10 result held while idle", msg_out, 7);

    // R5 / R6 / R4: exhaustive over nonzero keys and all messages
    for (int k = 1; k < (1 << W); k++) begin
      for (int m = 0; m < (1 << W); m++) begin
        int wk;
        c = tb_mul(W'(k), W'(m), POLY_IRR);
        run(c, W'(k), POLY_IRR, 1'b0, n);
        chk(found && !miss && msg_out == W'(m) && !ambig, "R5 correct key recovers message", msg_out, m);
        chk(n == (1 << W) + 2 + m, "R7 latency tracks candidate", n, (1 << W) + 2 + m);
        wk = (k % ((1 << W) - 1)) + 1;
        run(c, W'(wk), POLY_IRR, 1'b0, n);
        if (m != 0)
          chk(found && msg_out != W'(m), "R6 wrong key gives other message", msg_out, m);
        chk(!found || tb_mul(W'(wk), msg_out, POLY_IRR) == c, "R4 reported product matches", msg_out, m);
      end
    end

    // R10: new start clears previous flags at once
    @(negedge clk);
    cipher_in = 4'd5; key_in = 4'd0; poly_in = POLY_IRR; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !found && !miss && !ambig, "R10 flags cleared on start", {busy, found, miss, ambig}, 8);
    while (busy) @(negedge clk);
    // R8: key 0, nonzero cipher (5) -> miss
    chk(miss && !found, "R8 zero key nonzero cipher misses", {found, miss}, 1);

    // R7: miss latency
    run(4'd9, 4'd0, POLY_IRR, 1'b0, n);
    chk(n == (1 << (W + 1)) + 1, "R7 busy cycles on miss", n, (1 << (W + 1)) + 1);
    chk(miss && !found && !ambig, "R8 miss flags", {found, miss, ambig}, 2);

    // R9: key 0, cipher 0
    run(4'd0, 4'd0, POLY_IRR, 1'b0, n);
    chk(found && ambig && msg_out == 0, "R9 ambiguous zero", {found, ambig, msg_out}, 6'b110000);

    // R3: start during run is ignored
    c = tb_mul(4'd9, 4'd11, POLY_IRR);
    run(c, 4'd9, POLY_IRR, 1'b1, n);
    chk(found && msg_out == 11, "R3 mid-run start ignored", msg_out, 11);
    chk(n == (1 << W) + 2 + 11, "R3 mid-run start no restart", n, (1 << W) + 2 + 11);
    hm = msg_out; hf = found; hmiss = miss;
    repeat (3) @(negedge clk);
    chk(!busy && msg_out == hm && found == hf && miss == hmiss, "R3 no second run queued", busy, 0);

    // R11: reducible x^4, key x^2: candidates 1 and 5 give 4, lowest wins
    run(4'd4, 4'd4, 4'b0000, 1'b0, n);
    chk(found && msg_out == 1, "R11 lowest duplicate wins", msg_out, 1);
    // R11: key x: candidates 0 and 8 give 0
    run(4'd0, 4'd2, 4'b0000, 1'b0, n);
    chk(found && msg_out == 0 && !ambig, "R11 lowest duplicate zero", msg_out, 0);

    summary();
  end

endmodule